// File: doc/BRIEF.md
# Line-Buffered Pixel-Replicating Video Scaler

This block shows a small framebuffer on a 1024x768 raster. It generates its own raster timing. During the horizontal blanking just before the first output line of each source line, it fetches that source line from an external byte-wide memory port into an on-chip line store. It then plays the line back once for each output line that the source line covers, repeating each source pixel along the line. Screen memory is never read while the visible area is being scanned. Each source line is fetched once per frame, no matter how many output lines repeat it.

There are three geometries. In the first, a 512x256 image at 2 bits per pixel is shown with each pixel as a 2-wide, 3-tall block. In the second, a 512x384 image at 2 bits per pixel is shown with 2x2 blocks; it fills a 48 KB screen area. In the third, a 256x192 image at 8 bits per pixel is shown with 4x4 blocks; it also fills 48 KB. The screen base address is programmable, for example 0x1C000. Palette lookup and colour decoding belong to a later stage. The raw pixel code is delivered with a valid strobe, together with active-low horizontal and vertical sync.

Top module: `line_scaler`

## Requirements
- R1: Each line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks and each frame V_ACTIVE+V_FP+V_SYNC+V_BP lines. The defaults are 1024+24+136+160 = 1344 clocks and 768+3+6+29 = 806 lines. `hsync_n` is low for line positions H_ACTIVE+H_FP up to but not including H_ACTIVE+H_FP+H_SYNC. `vsync_n` is low for whole lines V_ACTIVE+V_FP up to but not including V_ACTIVE+V_FP+V_SYNC. Both syncs are high at all other times.
- R2: `pix_valid` is high exactly for line positions below H_ACTIVE on lines below V_ACTIVE. `pix_data` is zero whenever `pix_valid` is low.
- R3: Mode code 0 selects 2x3 blocks at 2 bits per pixel. Four pixels are packed per byte, with the leftmost pixel in bits 7:6 and the rightmost in bits 1:0. Each source line is H_ACTIVE/8 bytes. The 2-bit code is presented zero-extended in `pix_data[1:0]`.
- R4: Mode code 1 selects 2x2 blocks with the same 2-bit packing and line length as mode 0.
- R5: Mode code 2 selects 4x4 blocks at one byte per pixel. Each source line is H_ACTIVE/4 bytes, and the byte is presented unchanged on `pix_data`.
- R6: `rd_req` is never high in a cycle where `pix_valid` is high. Each frame issues exactly (source lines) x (line bytes) reads, so every source line is fetched once.
- R7: In each frame the reads start at the base address and climb by one per read with no gap. Each source line therefore starts one line length above the previous one.
- R8: Mode and base are sampled once per frame, in the cycle where horizontal blanking begins on the frame's final line. A change made mid-frame takes effect from the next frame.
- R9: `rd_data` must carry the byte at `rd_addr` exactly MEM_LAT cycles after a cycle in which `rd_req` is high.
- R10: While reset is high, `pix_valid` = 0, `pix_data` = 0, both syncs = 1 and `rd_req` = 0. After reset, the output stream starts at position 0 of the frame's final line, so the first visible line follows one blanking line later.
- R11: The line store has two banks. A fetch fills the bank not being shown, and it always completes before the line that uses it begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Geometry select: 0 = 2x3, 1 = 2x2, 2 = 4x4 at 8 bpp |
| base_i | input | ADDR_W | Byte address of the first screen byte |
| rd_req | output | 1 | Memory read strobe, one byte per cycle |
| rd_addr | output | ADDR_W | Byte address of the read |
| rd_data | input | 8 | Read data, MEM_LAT cycles after the request |
| pix_valid | output | 1 | High inside the visible area |
| pix_data | output | 8 | Pixel code, zero outside the visible area |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The embedded properties are checked on every cycle. They cover four things: memory reads never overlap visible output, fetch addresses climb by exactly one within a burst, every fetch has drained before the next line begins, and syncs and blanked data keep their relation to `pix_valid`. Only the directed scenarios can show the end-to-end picture. That picture has several parts: each replicated pixel carries the right byte from the right address for every mode, a frame reads exactly its screen area from the chosen base, and a mode or base change waits for the frame boundary.

// File: rtl/ls_pkg.sv
package ls_pkg;

    typedef enum logic [1:0] {
        MODE_HI2   = 2'd0,
        MODE_SQ2   = 2'd1,
        MODE_BYTE4 = 2'd2,
        MODE_RSVD  = 2'd3
    } scale_mode_t;

    typedef struct packed {
        logic active;
        logic hs_n;
        logic vs_n;
    } raster_flags_t;

    function automatic scale_mode_t decode_mode(logic [1:0] code);
        case (code)
            2'd1:    return MODE_SQ2;
            2'd2:    return MODE_BYTE4;
            default: return MODE_HI2;
        endcase
    endfunction

    function automatic logic is_byte_mode(scale_mode_t m);
        return m == MODE_BYTE4;
    endfunction

    // output lines per source line
    function automatic logic [2:0] vrep_of(scale_mode_t m);
        case (m)
            MODE_SQ2:   return 3'd2;
            MODE_BYTE4: return 3'd4;
            default:    return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/ls_timing.sv
module ls_timing
    import ls_pkg::*;
#(
    parameter int H_ACTIVE = 1024,
    parameter int H_FP     = 24,
    parameter int H_SYNC   = 136,
    parameter int H_BP     = 160,
    parameter int V_ACTIVE = 768,
    parameter int V_FP     = 3,
    parameter int V_SYNC   = 6,
    parameter int V_BP     = 29,
    parameter int HW       = $clog2(H_ACTIVE + H_FP + H_SYNC + H_BP)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] h_cnt,
    output raster_flags_t flags,
    output logic          blank_start,
    output logic          line_end,
    output logic          frame_tail,
    output logic          v_act,
    output logic          last_act_line
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int VW      = $clog2(V_TOTAL);

    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_VIS  = HW'(H_ACTIVE);
    localparam logic [HW-1:0] HS_ON  = HW'(H_ACTIVE + H_FP);
    localparam logic [HW-1:0] HS_OFF = HW'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_VIS  = VW'(V_ACTIVE);
    localparam logic [VW-1:0] V_VEND = VW'(V_ACTIVE - 1);
    localparam logic [VW-1:0] VS_ON  = VW'(V_ACTIVE + V_FP);
    localparam logic [VW-1:0] VS_OFF = VW'(V_ACTIVE + V_FP + V_SYNC);

    logic [VW-1:0] v_cnt;

    // reset parks the raster on the final line so the first fetch precedes line 0
    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt <= '0;
            v_cnt <= V_LAST;
        end else if (h_cnt == H_LAST) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    assign blank_start   = (h_cnt == H_VIS);
    assign line_end      = (h_cnt == H_LAST);
    assign frame_tail    = (v_cnt == V_LAST);
    assign v_act         = (v_cnt < V_VIS);
    assign last_act_line = (v_cnt == V_VEND);

    always_comb begin
        flags.active = (h_cnt < H_VIS) && v_act;
        flags.hs_n   = !((h_cnt >= HS_ON) && (h_cnt < HS_OFF));
        flags.vs_n   = !((v_cnt >= VS_ON) && (v_cnt < VS_OFF));
    end

endmodule

// File: rtl/ls_fetch.sv
module ls_fetch
    import ls_pkg::*;
#(
    parameter int H_ACTIVE = 1024,
    parameter int ADDR_W   = 20,
    parameter int MEM_LAT  = 1,
    parameter int LB_AW    = $clog2(H_ACTIVE / 4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              blank_start,
    input  logic              line_end,
    input  logic              frame_tail,
    input  logic              v_act,
    input  logic              last_act_line,
    input  logic              disp_active,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [LB_AW-1:0]  wr_idx,
    output logic              wr_bank,
    output scale_mode_t       mode_q,
    output logic              disp_bank
);
    localparam int BYTES_NARROW = H_ACTIVE / 8;
    localparam int BYTES_WIDE   = H_ACTIVE / 4;

    logic [ADDR_W-1:0] row_addr;
    logic [2:0]        rep;
    logic              fill_on;
    logic [LB_AW-1:0]  fill_idx;
    logic              swap_pend;
    logic [LB_AW-1:0]  idx_q;
    logic [LB_AW:0]    line_len;
    logic              fill_last;
    logic              rep_done;
    logic              start_first;
    logic              start_next;

    assign line_len    = is_byte_mode(mode_q) ? (LB_AW+1)'(BYTES_WIDE)
                                              : (LB_AW+1)'(BYTES_NARROW);
    assign fill_last   = ({1'b0, fill_idx} == line_len - 1'b1);
    assign rep_done    = (rep == vrep_of(mode_q) - 3'd1);
    assign start_first = blank_start && frame_tail;
    assign start_next  = blank_start && v_act && !last_act_line && rep_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_HI2;
            row_addr  <= '0;
            rep       <= '0;
            fill_on   <= 1'b0;
            fill_idx  <= '0;
            swap_pend <= 1'b0;
            disp_bank <= 1'b0;
            rd_req    <= 1'b0;
            rd_addr   <= '0;
            idx_q     <= '0;
        end else begin
            rd_req  <= fill_on;
            rd_addr <= row_addr + ADDR_W'(fill_idx);
            idx_q   <= fill_idx;

            if (fill_on) begin
                fill_idx <= fill_idx + 1'b1;
                if (fill_last) fill_on <= 1'b0;
            end

            if (start_first) begin
                mode_q    <= decode_mode(mode_i);
                row_addr  <= base_i;
                fill_on   <= 1'b1;
                fill_idx  <= '0;
                swap_pend <= 1'b1;
            end else if (start_next) begin
                row_addr  <= row_addr + ADDR_W'(line_len);
                fill_on   <= 1'b1;
                fill_idx  <= '0;
                swap_pend <= 1'b1;
            end

            if (line_end) begin
                if (swap_pend) begin
                    disp_bank <= ~disp_bank;
                    swap_pend <= 1'b0;
                end
                if (frame_tail)
                    rep <= '0;
                else if (v_act)
                    rep <= rep_done ? 3'd0 : rep + 3'd1;
            end
        end
    end

    // return path: tag each request with its store index for MEM_LAT cycles
    logic             pv   [MEM_LAT];
    logic [LB_AW-1:0] pidx [MEM_LAT];

    for (genvar s = 0; s < MEM_LAT; s++) begin : g_lat
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                pv[0]   <= rst ? 1'b0 : rd_req;
                pidx[0] <= idx_q;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                pv[s]   <= rst ? 1'b0 : pv[s-1];
                pidx[s] <= pidx[s-1];
            end
        end
    end

    assign wr_en   = pv[MEM_LAT-1];
    assign wr_idx  = pidx[MEM_LAT-1];
    assign wr_bank = ~disp_bank;

    assert_read_in_blank_R6: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> !disp_active);

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && $past(rd_req)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    assert_fill_drained_R11: assert property (@(posedge clk) disable iff (rst)
        line_end |-> (!fill_on && !wr_en));

endmodule

// File: rtl/ls_linebuf.sv
module ls_linebuf #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 2 ** (AW + 1);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_bank, wr_idx}] <= wr_data;
    end

    assign rd_data = mem[{rd_bank, rd_idx}];

endmodule

// File: rtl/ls_pixel.sv
module ls_pixel
    import ls_pkg::*;
#(
    parameter int HW    = 11,
    parameter int LB_AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [HW-1:0]    h_cnt,
    input  raster_flags_t    flags,
    input  scale_mode_t      mode_q,
    input  logic [7:0]       rd_byte,
    output logic [LB_AW-1:0] rd_idx,
    output logic             pix_valid,
    output logic [7:0]       pix_data,
    output logic             hsync_n,
    output logic             vsync_n
);
    logic          byte_m;
    logic [HW-1:0] sx;
    logic [1:0]    sel;
    logic [7:0]    shifted;
    logic [7:0]    pix_next;

    assign byte_m  = is_byte_mode(mode_q);
    assign sx      = byte_m ? (h_cnt >> 2) : (h_cnt >> 1);
    assign rd_idx  = byte_m ? LB_AW'(sx) : LB_AW'(sx >> 2);
    assign sel     = sx[1:0];
    // leftmost pixel of a byte sits in the top two bits
    assign shifted = rd_byte >> {~sel, 1'b0};
    assign pix_next = byte_m ? rd_byte : {6'b0, shifted[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix_data  <= '0;
            hsync_n   <= 1'b1;
            vsync_n   <= 1'b1;
        end else begin
            pix_valid <= flags.active;
            pix_data  <= flags.active ? pix_next : 8'h00;
            hsync_n   <= flags.hs_n;
            vsync_n   <= flags.vs_n;
        end
    end

    assert_blank_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> (pix_data == 8'h00));

    assert_sync_in_blank_R1: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n || !vsync_n) |-> !pix_valid);

    assert_two_bit_code_R3: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !is_byte_mode(mode_q)) |-> (pix_data[7:2] == 6'b0));

endmodule

// File: rtl/line_scaler.sv
module line_scaler
    import ls_pkg::*;
#(
    parameter int H_ACTIVE = 1024,
    parameter int H_FP     = 24,
    parameter int H_SYNC   = 136,
    parameter int H_BP     = 160,
    parameter int V_ACTIVE = 768,
    parameter int V_FP     = 3,
    parameter int V_SYNC   = 6,
    parameter int V_BP     = 29,
    parameter int ADDR_W   = 20,
    parameter int MEM_LAT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              pix_valid,
    output logic [7:0]        pix_data,
    output logic              hsync_n,
    output logic              vsync_n
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int LB_AW   = $clog2(H_ACTIVE / 4);

    logic [HW-1:0]    h_cnt;
    raster_flags_t    flags;
    logic             blank_start, line_end, frame_tail, v_act, last_act_line;
    logic             wr_en, wr_bank, disp_bank;
    logic [LB_AW-1:0] wr_idx, rd_idx;
    logic [7:0]       lb_byte;
    scale_mode_t      mode_q;

    ls_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HW(HW)
    ) u_timing (
        .clk(clk), .rst(rst), .h_cnt(h_cnt), .flags(flags),
        .blank_start(blank_start), .line_end(line_end), .frame_tail(frame_tail),
        .v_act(v_act), .last_act_line(last_act_line)
    );

    ls_fetch #(
        .H_ACTIVE(H_ACTIVE), .ADDR_W(ADDR_W), .MEM_LAT(MEM_LAT), .LB_AW(LB_AW)
    ) u_fetch (
        .clk(clk), .rst(rst), .mode_i(mode_i), .base_i(base_i),
        .blank_start(blank_start), .line_end(line_end), .frame_tail(frame_tail),
        .v_act(v_act), .last_act_line(last_act_line), .disp_active(flags.active),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_bank(wr_bank),
        .mode_q(mode_q), .disp_bank(disp_bank)
    );

    ls_linebuf #(.AW(LB_AW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .wr_data(rd_data), .rd_bank(disp_bank), .rd_idx(rd_idx), .rd_data(lb_byte)
    );

    ls_pixel #(.HW(HW), .LB_AW(LB_AW)) u_pixel (
        .clk(clk), .rst(rst), .h_cnt(h_cnt), .flags(flags), .mode_q(mode_q),
        .rd_byte(lb_byte), .rd_idx(rd_idx), .pix_valid(pix_valid),
        .pix_data(pix_data), .hsync_n(hsync_n), .vsync_n(vsync_n)
    );

endmodule

// File: tb/sim_line_scaler.sv
`timescale 1ns/1ps
module sim_line_scaler;
    localparam int HA = 32, HFP = 4, HS = 4, HBP = 8;
    localparam int VA = 24, VFP = 2, VS = 2, VBP = 2;
    localparam int AW = 20, LAT = 1;
    localparam int HT = HA + HFP + HS + HBP;
    localparam int VT = VA + VFP + VS + VBP;
    localparam int FT = HT * VT;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic [AW-1:0] base = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = 8'h00;
    logic          pix_valid;
    logic [7:0]    pix_data;
    logic          hsync_n, vsync_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    line_scaler #(
        .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
        .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
        .ADDR_W(AW), .MEM_LAT(LAT)
    ) u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .base_i(base),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .hsync_n(hsync_n), .vsync_n(vsync_n)
    );

    function automatic logic [7:0] pat(logic [AW-1:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory model: one-cycle latency (R9)
    always_ff @(posedge clk) if (rd_req) rd_data <= pat(rd_addr);

    function automatic int vrep(int m);  return (m == 2) ? 4 : (m == 1) ? 2 : 3; endfunction
    function automatic int hrep(int m);  return (m == 2) ? 4 : 2; endfunction
    function automatic int lbytes(int m); return (m == 2) ? HA / 4 : HA / 8; endfunction

    function automatic int exp_pix(int m, int b, int h, int l);
        int sx, sy, by;
        if (!(h < HA && l < VA)) return 0;
        sx = h / hrep(m);
        sy = l / vrep(m);
        if (m == 2) return int'(pat(AW'(b + sy * lbytes(m) + sx)));
        by = int'(pat(AW'(b + sy * lbytes(m) + sx / 4)));
        return (by >> (6 - 2 * (sx % 4))) & 3;
    endfunction

    task automatic check(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_reset();
        mode = 2'd2;
        base = 20'h1C000;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R10 pix_valid in reset", pix_valid == 1'b0, int'(pix_valid), 0);
        check("R10 pix_data in reset", pix_data == 8'h00, int'(pix_data), 0);
        check("R10 hsync_n in reset", hsync_n == 1'b1, int'(hsync_n), 1);
        check("R10 vsync_n in reset", vsync_n == 1'b1, int'(vsync_n), 1);
        check("R10 rd_req in reset", rd_req == 1'b0, int'(rd_req), 0);
    endtask

    // runs whole frames from reset, compares every output position with the model
    task automatic run_scenario(string pix_tag, int m0, int b0, int change_at,
                                int m1, int b1, int nframes);
        int eff_m = m0, eff_b = b0, exp_addr = b0;
        int reads = 0, exp_reads = 0;
        int pix_bad = 0, hs_bad = 0, vs_bad = 0, addr_bad = 0, overlap = 0;
        int pa = 0, pe = 0, aa = 0, ae = 0;
        mode = 2'(m0);
        base = AW'(b0);
        do_reset();
        for (int p = 0; p < nframes * FT; p++) begin
            int h, l, ed;
            bit ev, ehs, evs;
            @(posedge clk);
            @(negedge clk);
            h = p % HT;
            l = (VT - 1 + p / HT) % VT;
            if (h == HA && l == VT - 1) begin
                eff_m = int'(mode);
                eff_b = int'(base);
                exp_addr = eff_b;
                exp_reads += (VA / vrep(eff_m)) * lbytes(eff_m);
            end
            ev  = (h < HA) && (l < VA);
            ed  = exp_pix(eff_m, eff_b, h, l);
            ehs = !((h >= HA + HFP) && (h < HA + HFP + HS));
            evs = !((l >= VA + VFP) && (l < VA + VFP + VS));
            if (pix_valid != ev || int'(pix_data) != ed) begin
                if (pix_bad == 0) begin pa = int'(pix_data); pe = ed; end
                pix_bad++;
            end
            if (hsync_n != ehs) hs_bad++;
            if (vsync_n != evs) vs_bad++;
            if (rd_req) begin
                reads++;
                if (int'(rd_addr) != exp_addr) begin
                    if (addr_bad == 0) begin aa = int'(rd_addr); ae = exp_addr; end
                    addr_bad++;
                end
                exp_addr++;
                if (pix_valid) overlap++;
            end
            if (p == change_at) begin
                mode = 2'(m1);
                base = AW'(b1);
            end
        end
        check({pix_tag, " replicated pixel stream"}, pix_bad == 0, pa, pe);
        check("R1 R10 hsync_n position", hs_bad == 0, hs_bad, 0);
        check("R1 R10 vsync_n lines", vs_bad == 0, vs_bad, 0);
        check("R6 reads per frame", reads == exp_reads, reads, exp_reads);
        check("R6 read during visible output", overlap == 0, overlap, 0);
        check("R7 read address sequence", addr_bad == 0, aa, ae);
    endtask

    task automatic test_mode0();
        run_scenario("R2 R3 R9", 0, 'h1C000, -1, 0, 0, 2);
    endtask

    task automatic test_mode1();
        run_scenario("R2 R4", 1, 'h00123, -1, 0, 0, 2);
    endtask

    task automatic test_mode2();
        // widest fetch: exercises completion before line start (R11)
        run_scenario("R2 R5 R11", 2, 'h1C000, -1, 0, 0, 2);
    endtask

    task automatic test_midframe_change();
        run_scenario("R8", 1, 'h04000, HT * 10 + 5, 2, 'h1C000, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
            finish_sim();
        end
    end

    initial begin
        test_reset();
        test_mode0();
        test_mode1();
        test_mode2();
        test_midframe_change();
        finish_sim();
    end

endmodule